// File: doc/BRIEF.md
# Centre-Out Row-Group Readout Sequencer

This block produces the row timing for one half of a pixel array whose column lines are split at the array centre. Rows are handled six at a time: the six rows of a group share one bias-select strobe, one select strobe and one reset strobe. The groups are visited starting next to the centre and moving outward, either toward lower or toward higher absolute group numbers depending on which half the block serves. A mirrored instance drives the other half, so two groups of six (twelve rows) are read in each group period.

Consecutive groups are sampled into two interleaved sample-and-hold branches in turn. After each group has been sampled and reset, a one-cycle done pulse tells the conversion stage which branch now holds fresh data. A centred region of interest is selected by a total row count that covers both halves. The count is rounded down to a multiple of twelve, and each half then reads the same number of groups next to the centre.

Top module: `centre_out_rowseq`

## Requirements
- R1: While reset is held and after its release, all strobes (`bsel`, `sel`, `sh1`, `sh2`, `rst_row`) and `grp_done` are low until a frame is started.
- R2: Groups are numbered absolutely from 0 to 2*G-1 (G = groups per half, 172 by default), with the centre boundary between G-1 and G. With `dir_up`=1 the first group is G-1 and each later group is one lower. With `dir_up`=0 the first group is G and each later group is one higher. `grp_addr` does not change while a group's `bsel` is high.
- R3: For each group, `bsel` and `sel` rise together in the first cycle after the accepting edge (or right after the previous group) and stay high for `sel_len`+`sh_len` cycles.
- R4: The sample strobe is high during the last `sh_len` cycles of the select window. Group k of a frame (k from 0) uses `sh1` when k is even and `sh2` when k is odd. The two strobes are never high together, and neither is high without `sel`.
- R5: Once `sel` falls, `rst_row` is high for `rst_len` cycles with every other strobe low. The next group's select window then follows at once.
- R6: The groups per half read in a frame equal floor(`roi_rows`/12), raised to 1 if smaller and limited to G if larger.
- R7: One cycle after each group's last reset cycle, `grp_done` is high for exactly one cycle. `done_branch` then holds that group's branch: 0 for `sh1`, 1 for `sh2`.
- R8: A phase length of 0 acts as a length of 1.
- R9: `frame_start` is accepted only when no frame is running. Direction, region and phase lengths are captured at that edge, and changes during the frame have no effect.
- R10: After the last group's done pulse, all strobes stay low until the next accepted `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start a frame when idle |
| dir_up | input | 1 | 1: walk toward lower group numbers; 0: toward higher |
| roi_rows | input | ROI_W (12) | Total rows across both halves for the region of interest |
| sel_len | input | PH_W (8) | Cycles of select before sampling |
| sh_len | input | PH_W (8) | Cycles of the sample strobe |
| rst_len | input | PH_W (8) | Cycles of the reset strobe |
| grp_addr | output | ADDR_W (9) | Absolute group number being driven |
| bsel | output | 1 | Bias select for the current group |
| sel | output | 1 | Row select for the current group |
| rst_row | output | 1 | Pixel reset for the current group |
| sh1 | output | 1 | Sample strobe, branch 0 |
| sh2 | output | 1 | Sample strobe, branch 1 |
| grp_done | output | 1 | One-cycle pulse after a group is sampled and reset |
| done_branch | output | 1 | Branch of the finished group, valid with `grp_done` |

## Verification
A phase timer that reloads with the wrong value shifts every later strobe edge and shows up as a wrong group period at the first transition after the error. A walker whose branch bit or address slips is seen at the next group boundary, as the wrong sample strobe or as an address that is not one step further from the centre. A wrong remaining-group count is seen only at the frame's end, as a done pulse too few or too many and strobes running on when they should stop. For this reason the bench follows every cycle of each frame through to two cycles past its end.

// File: rtl/rgs_pkg.sv
package rgs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEL  = 2'd1,
    PH_SH   = 2'd2,
    PH_RST  = 2'd3
  } phase_e;

endpackage

// File: rtl/rgs_roi_calc.sv
module rgs_roi_calc #(
  parameter int GROUP_ROWS = 6,
  parameter int GROUPS     = 172,
  parameter int ROI_W      = 12,
  parameter int CNT_W      = 8
) (
  input  logic [ROI_W-1:0] roi_rows,
  output logic [CNT_W-1:0] n_groups
);

  localparam int SPAN = 2 * GROUP_ROWS;

  logic [ROI_W-1:0] whole;

  assign whole = roi_rows / ROI_W'(SPAN);

  always_comb begin
    if (whole == '0) begin
      n_groups = CNT_W'(1);
    end else if (whole > ROI_W'(GROUPS)) begin
      n_groups = CNT_W'(GROUPS);
    end else begin
      n_groups = whole[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/rgs_phase_timer.sv
module rgs_phase_timer #(
  parameter int PH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PH_W-1:0] load_len,
  output logic            expire
);

  logic [PH_W-1:0] cnt_q;
  logic [PH_W-1:0] cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) begin
      cnt_d = (load_len == '0) ? '0 : load_len - PH_W'(1);
    end else begin
      cnt_d = cnt_q - PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/rgs_group_walker.sv
module rgs_group_walker #(
  parameter int GROUPS = 172,
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic              up,
  input  logic [CNT_W-1:0]  n_groups,
  output logic [ADDR_W-1:0] addr,
  output logic              branch,
  output logic              last
);

  localparam logic [ADDR_W-1:0] CTR_LO = ADDR_W'(GROUPS - 1);
  localparam logic [ADDR_W-1:0] CTR_HI = ADDR_W'(GROUPS);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              branch_q, branch_d;
  logic              up_q, up_d;
  logic              en;

  always_comb begin
    en       = start || step;
    addr_d   = addr_q;
    left_d   = left_q;
    branch_d = branch_q;
    up_d     = up_q;
    if (start) begin
      addr_d   = up ? CTR_LO : CTR_HI;
      left_d   = n_groups - CNT_W'(1);
      branch_d = 1'b0;
      up_d     = up;
    end else if (step) begin
      addr_d   = up_q ? (addr_q - ADDR_W'(1)) : (addr_q + ADDR_W'(1));
      left_d   = left_q - CNT_W'(1);
      branch_d = ~branch_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      left_q   <= '0;
      branch_q <= 1'b0;
      up_q     <= 1'b0;
    end else if (en) begin
      addr_q   <= addr_d;
      left_q   <= left_d;
      branch_q <= branch_d;
      up_q     <= up_d;
    end
  end

  assign addr   = addr_q;
  assign branch = branch_q;
  assign last   = (left_q == '0);

endmodule

// File: rtl/centre_out_rowseq.sv
module centre_out_rowseq
  import rgs_pkg::*;
#(
  parameter int ROWS_HALF  = 1032,
  parameter int GROUP_ROWS = 6,
  parameter int PH_W       = 8,
  parameter int ROI_W      = 12,
  localparam int GROUPS    = ROWS_HALF / GROUP_ROWS,
  localparam int ADDR_W    = $clog2(2 * GROUPS),
  localparam int CNT_W     = $clog2(GROUPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              dir_up,
  input  logic [ROI_W-1:0]  roi_rows,
  input  logic [PH_W-1:0]   sel_len,
  input  logic [PH_W-1:0]   sh_len,
  input  logic [PH_W-1:0]   rst_len,
  output logic [ADDR_W-1:0] grp_addr,
  output logic              bsel,
  output logic              sel,
  output logic              rst_row,
  output logic              sh1,
  output logic              sh2,
  output logic              grp_done,
  output logic              done_branch
);

  phase_e            state_q, state_d;
  logic [PH_W-1:0]   sh_len_q, rst_len_q, sel_len_q;
  logic              start;
  logic              expire;
  logic              tmr_load;
  logic [PH_W-1:0]   tmr_len;
  logic              step;
  logic              last;
  logic              branch;
  logic [CNT_W-1:0]  n_groups;
  logic              grp_end;
  logic              done_q, done_br_q;

  rgs_roi_calc #(
    .GROUP_ROWS(GROUP_ROWS),
    .GROUPS    (GROUPS),
    .ROI_W     (ROI_W),
    .CNT_W     (CNT_W)
  ) u_roi (
    .roi_rows(roi_rows),
    .n_groups(n_groups)
  );

  rgs_phase_timer #(
    .PH_W(PH_W)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_len(tmr_len),
    .expire  (expire)
  );

  rgs_group_walker #(
    .GROUPS(GROUPS),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .step    (step),
    .up      (dir_up),
    .n_groups(n_groups),
    .addr    (grp_addr),
    .branch  (branch),
    .last    (last)
  );

  assign start   = (state_q == PH_IDLE) && frame_start;
  assign grp_end = (state_q == PH_RST) && expire;
  assign step    = grp_end && !last;

  // next phase and timer reload selection
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_len  = sel_len_q;
    unique case (state_q)
      PH_IDLE: begin
        if (frame_start) begin
          state_d  = PH_SEL;
          tmr_load = 1'b1;
          tmr_len  = sel_len;
        end
      end
      PH_SEL: begin
        if (expire) begin
          state_d  = PH_SH;
          tmr_load = 1'b1;
          tmr_len  = sh_len_q;
        end
      end
      PH_SH: begin
        if (expire) begin
          state_d  = PH_RST;
          tmr_load = 1'b1;
          tmr_len  = rst_len_q;
        end
      end
      PH_RST: begin
        if (expire) begin
          if (last) begin
            state_d = PH_IDLE;
          end else begin
            state_d  = PH_SEL;
            tmr_load = 1'b1;
            tmr_len  = sel_len_q;
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // phase lengths captured when a frame is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_len_q <= '0;
      sh_len_q  <= '0;
      rst_len_q <= '0;
    end else if (start) begin
      sel_len_q <= sel_len;
      sh_len_q  <= sh_len;
      rst_len_q <= rst_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      done_br_q <= 1'b0;
    end else begin
      done_q <= grp_end;
      if (grp_end) begin
        done_br_q <= branch;
      end
    end
  end

  assign bsel        = (state_q == PH_SEL) || (state_q == PH_SH);
  assign sel         = (state_q == PH_SEL) || (state_q == PH_SH);
  assign sh1         = (state_q == PH_SH) && !branch;
  assign sh2         = (state_q == PH_SH) && branch;
  assign rst_row     = (state_q == PH_RST);
  assign grp_done    = done_q;
  assign done_branch = done_br_q;

endmodule

// File: rtl/rgs_chk.sv
module rgs_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] grp_addr,
  input logic              bsel,
  input logic              sel,
  input logic              rst_row,
  input logic              sh1,
  input logic              sh2,
  input logic              grp_done
);

  // R3: select never without bias select
  a_r3_sel_needs_bsel: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> bsel);

  // R2: address held while a group is selected
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bsel && $past(bsel)) |-> $stable(grp_addr));

  // R4: branches exclusive and only within select
  a_r4_sh_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sh1 && sh2));

  a_r4_sh_in_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (sh1 || sh2) |-> sel);

  // R5: reset isolated and entered only from sampling
  a_r5_rst_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    rst_row |-> (!bsel && !sel && !sh1 && !sh2));

  a_r5_rst_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_row) |-> $past(sh1 || sh2));

  // R7: done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> !grp_done);

endmodule

bind centre_out_rowseq rgs_chk #(.ADDR_W(ADDR_W)) u_rgs_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .grp_addr(grp_addr),
  .bsel    (bsel),
  .sel     (sel),
  .rst_row (rst_row),
  .sh1     (sh1),
  .sh2     (sh2),
  .grp_done(grp_done)
);

// File: tb/tb_centre_out_rowseq.sv
module tb_centre_out_rowseq;

  localparam int CLK_PERIOD = 10;
  localparam int GROUPS     = 172;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        dir_up = 1'b0;
  logic [11:0] roi_rows = '0;
  logic [7:0]  sel_len = '0;
  logic [7:0]  sh_len = '0;
  logic [7:0]  rst_len = '0;
  logic [8:0]  grp_addr;
  logic        bsel, sel, rst_row, sh1, sh2, grp_done, done_branch;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  centre_out_rowseq dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .dir_up(dir_up),
    .roi_rows(roi_rows), .sel_len(sel_len), .sh_len(sh_len), .rst_len(rst_len),
    .grp_addr(grp_addr), .bsel(bsel), .sel(sel), .rst_row(rst_row),
    .sh1(sh1), .sh2(sh2), .grp_done(grp_done), .done_branch(done_branch)
  );

  task automatic expect_eq(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int groups_for(input int roi);
    int n;
    n = roi / 12;
    if (n < 1) n = 1;
    if (n > GROUPS) n = GROUPS;
    return n;
  endfunction

  function automatic int eff(input int len);
    return (len == 0) ? 1 : len;
  endfunction

  task automatic check_idle(input string tag);
    expect_eq(bsel, 0, tag, "bsel");
    expect_eq(sel, 0, tag, "sel");
    expect_eq(sh1, 0, tag, "sh1");
    expect_eq(sh2, 0, tag, "sh2");
    expect_eq(rst_row, 0, tag, "rst_row");
  endtask

  // Drives one frame and checks every cycle of it; noise disturbs
  // frame_start and configuration inputs while running (R9).
  task automatic run_frame(input bit up, input int roi, input int ts_raw,
                           input int tsh_raw, input int tr_raw, input bit noise);
    int n, ts, tsh, tr, per, total, dones;
    n     = groups_for(roi);           // R6
    ts    = eff(ts_raw);               // R8
    tsh   = eff(tsh_raw);
    tr    = eff(tr_raw);
    per   = ts + tsh + tr;
    total = n * per;
    dones = 0;
    @(negedge clk);
    frame_start = 1'b1;
    dir_up      = up;
    roi_rows    = 12'(roi);
    sel_len     = 8'(ts_raw);
    sh_len      = 8'(tsh_raw);
    rst_len     = 8'(tr_raw);
    @(negedge clk);
    for (int t = 1; t <= total + 2; t++) begin
      if (t <= total) begin
        int k, p;
        bit e_sel, e_sh;
        k = (t - 1) / per;
        p = (t - 1) % per;
        e_sel = (p < ts + tsh);
        e_sh  = e_sel && (p >= ts);
        expect_eq(bsel, e_sel, "R3", "bsel");
        expect_eq(sel, e_sel, "R3", "sel");
        expect_eq(sh1, e_sh && (k % 2 == 0), "R4", "sh1");
        expect_eq(sh2, e_sh && (k % 2 == 1), "R4", "sh2");
        expect_eq(rst_row, !e_sel, "R5", "rst_row");
        expect_eq(grp_addr, up ? (GROUPS - 1 - k) : (GROUPS + k), "R2", "grp_addr");
        expect_eq(grp_done, (k > 0) && (p == 0), "R7", "grp_done");
        if ((k > 0) && (p == 0)) expect_eq(done_branch, (k - 1) % 2, "R7", "done_branch");
      end else begin
        check_idle("R10");
        expect_eq(grp_done, (t == total + 1), "R7", "grp_done end");
        if (t == total + 1) expect_eq(done_branch, (n - 1) % 2, "R7", "done_branch end");
      end
      if (grp_done) dones++;
      if (noise && t <= total) begin
        frame_start = ($urandom_range(3, 0) == 0);
        dir_up      = 1'($urandom);
        roi_rows    = 12'($urandom);
        sel_len     = 8'($urandom_range(9, 0));
        sh_len      = 8'($urandom_range(9, 0));
        rst_len     = 8'($urandom_range(9, 0));
      end else begin
        frame_start = 1'b0;
      end
      @(negedge clk);
    end
    expect_eq(dones, n, "R6", "done pulse count");
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    // R1: during reset
    repeat (3) @(negedge clk);
    check_idle("R1");
    expect_eq(grp_done, 0, "R1", "grp_done in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1");
    expect_eq(grp_done, 0, "R1", "grp_done after reset");

    // directed corners
    run_frame(1'b1, 0,    2, 3, 1, 1'b0);  // R6 zero rows -> one group
    run_frame(1'b0, 11,   1, 1, 1, 1'b0);  // R6 below one group
    run_frame(1'b1, 25,   3, 2, 2, 1'b0);  // R6 rounds down to two
    run_frame(1'b0, 60,   0, 0, 0, 1'b0);  // R8 zero lengths
    run_frame(1'b1, 2064, 1, 1, 1, 1'b0);  // R6 full half
    run_frame(1'b0, 4095, 1, 1, 1, 1'b1);  // R6 clamp, R9 noise
    run_frame(1'b1, 48,   4, 2, 3, 1'b1);  // R9 ignored inputs

    // R10: idle gap with frame_start low
    repeat (4) begin
      @(negedge clk);
      check_idle("R10");
    end

    // constrained random frames
    for (int i = 0; i < 14; i++) begin
      run_frame(1'($urandom), $urandom_range(300, 0), $urandom_range(5, 0),
                $urandom_range(5, 0), $urandom_range(5, 0), 1'($urandom));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule